// File: doc/BRIEF.md
# Wide ECC Word to 32-bit Bus Adapter

This block joins a memory holding 72-bit words (64 data bits and 8 check bits) to a 32-bit system bus. On a read it accepts one stored word, runs it through a single-error-correct, double-error-detect check, and sends the corrected word onto the bus as two 32-bit beats. The lower half goes first and the upper half second. Data, valid and flags all change on the same clock edge.

When only half the memory is fitted, the upper 32 data bits do not exist. All 8 check bits are still kept. The missing bits are replaced by a constant before checking and before encoding. The constant is all zeros or all ones, picked by an input. In this half-width setup the two read beats are spaced one bus slot apart instead of coming back to back.

On the write side the block gathers bus words and produces a complete encoded 72-bit word for the memory. Writes therefore take longer than reads.

Top module: `wide_ecc_bus_adapter`

## Requirements
- R1: After reset is asserted, `bus_rd_valid_o`, `bus_rd_last_o`, `err_corr_o`, `err_uncorr_o` and `mem_wr_valid_o` are all low.
- R2: Memory word layout is as follows. Bits [63:0] hold data and bits [71:64] hold check bits. The Hamming positions 1..71 that are not powers of two hold data bits 0..63, in ascending order. Check bit j (j<7) is the XOR of all data bits whose Hamming position has bit j set. Check bit 7 makes the parity of all 72 bits even.
- R3: A read returns data bits [31:0] on the first beat with `bus_rd_last_o` low. It returns data bits [63:32] on the second beat with `bus_rd_last_o` high.
- R4: In full-width mode the first beat appears on the clock edge that samples `mem_rd_valid_i`, and the second beat appears on the next edge.
- R5: In half-width mode there is exactly one cycle with `bus_rd_valid_o` low between the first beat and the second beat.
- R6: A single flipped bit anywhere in the 72-bit word is corrected. `err_corr_o` is high on both beats and `err_uncorr_o` is low.
- R7: Two flipped bits raise `err_uncorr_o` on both beats with `err_corr_o` low. In that case the data is passed on exactly as received, with no correction.
- R8: A clean word gives the stored data with both error flags low.
- R9: In half-width mode, input bits [63:32] of a read word are ignored. Each of those bits is replaced by `fill_ones_i` before checking, so the upper beat returns that constant.
- R10: In full-width mode, two bus words are gathered with the lower half first. One cycle after the second word is accepted, `mem_wr_valid_o` pulses with the word {check, second, first}.
- R11: In half-width mode, each bus word produces a memory write one cycle later. Its data bits [63:32] equal `fill_ones_i` copied 32 times, and it is encoded per R2.
- R12: An error flag is only ever high while `bus_rd_valid_o` is high, and the two flags are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| half_mode_i | input | 1 | 1: half-width memory fitted |
| fill_ones_i | input | 1 | Constant used for the missing upper half |
| mem_rd_valid_i | input | 1 | A read word is present |
| mem_rd_word_i | input | 72 | Read word from memory |
| bus_rd_valid_o | output | 1 | Read beat valid |
| bus_rd_data_o | output | 32 | Read beat data |
| bus_rd_last_o | output | 1 | Marks the second (upper) beat |
| err_corr_o | output | 1 | Single-bit error was corrected |
| err_uncorr_o | output | 1 | Uncorrectable error was detected |
| bus_wr_valid_i | input | 1 | Write word from the bus is present |
| bus_wr_data_i | input | 32 | Write word from the bus |
| mem_wr_valid_o | output | 1 | Encoded word ready for memory |
| mem_wr_word_o | output | 72 | Encoded memory word |

## Verification
The assertions rely on two things about the inputs. First, `half_mode_i` and `fill_ones_i` stay stable while a transfer is in progress. Second, a new read is only offered once the previous read's second beat has been sent. The stimulus respects both: it changes the mode only between transfers and always waits out the full beat sequence of each read. It also never mixes an unfinished write pair with a mode switch.

// File: rtl/ecc_bus_pkg.sv
package ecc_bus_pkg;
  localparam int DATA_W = 64;
  localparam int HAM_W  = 7;
  localparam int CHK_W  = HAM_W + 1;
  localparam int WORD_W = DATA_W + CHK_W;
  localparam int BUS_W  = DATA_W / 2;
  localparam int MAX_POS = DATA_W + HAM_W;

  typedef enum logic [1:0] {RD_IDLE, RD_GAP, RD_HI} rd_state_e;

  // Hamming position of data bit k: k-th non power of two in 1..MAX_POS
  function automatic logic [HAM_W-1:0] data_pos(input int k);
    int n;
    logic [HAM_W-1:0] r;
    n = 0;
    r = '0;
    for (int p = 1; p <= MAX_POS; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (n == k) r = HAM_W'(p);
        n++;
      end
    end
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] ham_mask(input int j);
    logic [DATA_W-1:0] m;
    logic [HAM_W-1:0] p;
    m = '0;
    for (int k = 0; k < DATA_W; k++) begin
      p = data_pos(k);
      m[k] = p[j];
    end
    return m;
  endfunction
endpackage

// File: rtl/ecc_enc.sv
module ecc_enc
  import ecc_bus_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [CHK_W-1:0]  chk_o
);
  logic [HAM_W-1:0] ham;

  for (genvar j = 0; j < HAM_W; j++) begin : g_ham
    localparam logic [DATA_W-1:0] MASK = ham_mask(j);
    assign ham[j] = ^(data_i & MASK);
  end

  assign chk_o = {^{ham, data_i}, ham};
endmodule

// File: rtl/ecc_dec.sv
module ecc_dec
  import ecc_bus_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output logic [DATA_W-1:0] data_o,
  output logic              corr_o,
  output logic              uncorr_o
);
  logic [DATA_W-1:0] raw;
  logic [CHK_W-1:0]  stored, recalc;
  logic [HAM_W-1:0]  syn;
  logic              par_err, in_range;
  logic [DATA_W-1:0] flip;

  assign raw    = word_i[DATA_W-1:0];
  assign stored = word_i[WORD_W-1:DATA_W];

  ecc_enc u_enc (.data_i(raw), .chk_o(recalc));

  assign syn      = recalc[HAM_W-1:0] ^ stored[HAM_W-1:0];
  // overall parity of received word, folded through the recomputed bit
  assign par_err  = recalc[CHK_W-1] ^ stored[CHK_W-1] ^ (^syn);
  assign in_range = (syn <= HAM_W'(MAX_POS));

  for (genvar k = 0; k < DATA_W; k++) begin : g_flip
    localparam logic [HAM_W-1:0] POS = data_pos(k);
    assign flip[k] = (syn == POS);
  end

  assign corr_o   = par_err && in_range;
  assign uncorr_o = (!par_err && (syn != '0)) || (par_err && !in_range);
  assign data_o   = corr_o ? (raw ^ flip) : raw;
endmodule

// File: rtl/wide_ecc_bus_adapter.sv
module wide_ecc_bus_adapter
  import ecc_bus_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              half_mode_i,
  input  logic              fill_ones_i,
  input  logic              mem_rd_valid_i,
  input  logic [WORD_W-1:0] mem_rd_word_i,
  output logic              bus_rd_valid_o,
  output logic [BUS_W-1:0]  bus_rd_data_o,
  output logic              bus_rd_last_o,
  output logic              err_corr_o,
  output logic              err_uncorr_o,
  input  logic              bus_wr_valid_i,
  input  logic [BUS_W-1:0]  bus_wr_data_i,
  output logic              mem_wr_valid_o,
  output logic [WORD_W-1:0] mem_wr_word_o
);
  logic [BUS_W-1:0]  fill;
  logic [WORD_W-1:0] rd_eff;
  logic [DATA_W-1:0] dec_data;
  logic              dec_corr, dec_uncorr;
  rd_state_e         rd_state_q;
  logic [BUS_W-1:0]  rd_hi_q;
  logic              corr_q, uncorr_q;

  assign fill = {BUS_W{fill_ones_i}};

  // absent upper half replaced before checking
  assign rd_eff = half_mode_i
                ? {mem_rd_word_i[WORD_W-1:DATA_W], fill, mem_rd_word_i[BUS_W-1:0]}
                : mem_rd_word_i;

  ecc_dec u_dec (
    .word_i  (rd_eff),
    .data_o  (dec_data),
    .corr_o  (dec_corr),
    .uncorr_o(dec_uncorr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_state_q     <= RD_IDLE;
      bus_rd_valid_o <= 1'b0;
      bus_rd_last_o  <= 1'b0;
      bus_rd_data_o  <= '0;
      rd_hi_q        <= '0;
      corr_q         <= 1'b0;
      uncorr_q       <= 1'b0;
    end else begin
      unique case (rd_state_q)
        RD_IDLE: begin
          bus_rd_last_o <= 1'b0;
          if (mem_rd_valid_i) begin
            bus_rd_valid_o <= 1'b1;
            bus_rd_data_o  <= dec_data[BUS_W-1:0];
            rd_hi_q        <= dec_data[DATA_W-1:BUS_W];
            corr_q         <= dec_corr;
            uncorr_q       <= dec_uncorr;
            rd_state_q     <= half_mode_i ? RD_GAP : RD_HI;
          end else begin
            bus_rd_valid_o <= 1'b0;
          end
        end
        RD_GAP: begin
          bus_rd_valid_o <= 1'b0;
          rd_state_q     <= RD_HI;
        end
        RD_HI: begin
          bus_rd_valid_o <= 1'b1;
          bus_rd_last_o  <= 1'b1;
          bus_rd_data_o  <= rd_hi_q;
          rd_state_q     <= RD_IDLE;
        end
        default: rd_state_q <= RD_IDLE;
      endcase
    end
  end

  assign err_corr_o   = bus_rd_valid_o && corr_q;
  assign err_uncorr_o = bus_rd_valid_o && uncorr_q;

  // write gathering
  logic              wr_have_lo_q;
  logic [BUS_W-1:0]  wr_lo_q;
  logic [DATA_W-1:0] wr_data;
  logic [CHK_W-1:0]  wr_chk;
  logic              wr_fire;

  assign wr_data = half_mode_i ? {fill, bus_wr_data_i} : {bus_wr_data_i, wr_lo_q};
  assign wr_fire = bus_wr_valid_i && (half_mode_i || wr_have_lo_q);

  ecc_enc u_enc (.data_i(wr_data), .chk_o(wr_chk));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_have_lo_q   <= 1'b0;
      wr_lo_q        <= '0;
      mem_wr_valid_o <= 1'b0;
      mem_wr_word_o  <= '0;
    end else begin
      mem_wr_valid_o <= wr_fire;
      if (wr_fire) mem_wr_word_o <= {wr_chk, wr_data};
      if (bus_wr_valid_i && !half_mode_i) begin
        wr_have_lo_q <= !wr_have_lo_q;
        if (!wr_have_lo_q) wr_lo_q <= bus_wr_data_i;
      end
    end
  end
endmodule

// File: rtl/wide_ecc_bus_adapter_chk.sv
module wide_ecc_bus_adapter_chk
  import ecc_bus_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              half_mode_i,
  input logic              fill_ones_i,
  input logic              mem_rd_valid_i,
  input logic              bus_rd_valid_o,
  input logic              bus_rd_last_o,
  input logic              err_corr_o,
  input logic              err_uncorr_o,
  input logic              mem_wr_valid_o,
  input logic [WORD_W-1:0] mem_wr_word_o
);
  assert_rd_first_beat_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_valid_i |=> bus_rd_valid_o && !bus_rd_last_o);

  assert_full_pair_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rd_valid_o && !bus_rd_last_o && !half_mode_i |=> bus_rd_valid_o && bus_rd_last_o);

  assert_half_gap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rd_valid_o && !bus_rd_last_o && half_mode_i |=> !bus_rd_valid_o);

  assert_last_valid_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rd_last_o |-> bus_rd_valid_o);

  assert_flags_excl_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(err_corr_o && err_uncorr_o));

  assert_flags_beat_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_corr_o || err_uncorr_o) |-> bus_rd_valid_o);

  assert_wr_parity_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_valid_o |-> (^mem_wr_word_o) == 1'b0);

  assert_half_fill_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_valid_o && half_mode_i |-> mem_wr_word_o[DATA_W-1:BUS_W] == {BUS_W{fill_ones_i}});
endmodule

bind wide_ecc_bus_adapter wide_ecc_bus_adapter_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .half_mode_i   (half_mode_i),
  .fill_ones_i   (fill_ones_i),
  .mem_rd_valid_i(mem_rd_valid_i),
  .bus_rd_valid_o(bus_rd_valid_o),
  .bus_rd_last_o (bus_rd_last_o),
  .err_corr_o    (err_corr_o),
  .err_uncorr_o  (err_uncorr_o),
  .mem_wr_valid_o(mem_wr_valid_o),
  .mem_wr_word_o (mem_wr_word_o)
);

// File: tb/sim_wide_ecc_bus_adapter.sv
module sim_wide_ecc_bus_adapter;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        half_mode_i = 1'b0, fill_ones_i = 1'b0;
  logic        mem_rd_valid_i = 1'b0;
  logic [71:0] mem_rd_word_i = '0;
  logic        bus_rd_valid_o, bus_rd_last_o, err_corr_o, err_uncorr_o;
  logic [31:0] bus_rd_data_o;
  logic        bus_wr_valid_i = 1'b0;
  logic [31:0] bus_wr_data_i = '0;
  logic        mem_wr_valid_o;
  logic [71:0] mem_wr_word_o;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  wide_ecc_bus_adapter u0 (.*);

  task automatic check(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [71:0] b_encode(input logic [63:0] d);
    logic [6:0] h;
    logic [71:0] w;
    int k;
    h = '0;
    k = 0;
    for (int p = 1; p < 72; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (d[k]) h ^= 7'(p);
        k++;
      end
    end
    w = {1'b0, h, d};
    w[71] = ^w;
    return w;
  endfunction

  // read with up to two flipped bits (fa/fb < 0 means none)
  task automatic do_read(input logic [63:0] d_in, input int fa, input int fb);
    logic [63:0] d;
    logic [71:0] w, rx;
    logic [63:0] exp_d;
    int n_eff;
    d = d_in;
    if (half_mode_i) d[63:32] = {32{fill_ones_i}};
    w = b_encode(d);
    rx = w;
    n_eff = 0;
    if (fa >= 0) begin
      rx[fa] = ~rx[fa];
      if (!(half_mode_i && fa >= 32 && fa < 64)) n_eff++;
    end
    if (fb >= 0) begin
      rx[fb] = ~rx[fb];
      if (!(half_mode_i && fb >= 32 && fb < 64)) n_eff++;
    end
    exp_d = d;
    if (n_eff == 2) begin
      exp_d = rx[63:0];
      if (half_mode_i) exp_d[63:32] = {32{fill_ones_i}};
    end
    mem_rd_valid_i = 1'b1;
    mem_rd_word_i  = rx;
    @(negedge clk_i);
    mem_rd_valid_i = 1'b0;
    mem_rd_word_i  = '0;
    check(bus_rd_valid_o && !bus_rd_last_o, "R3 R4 first beat", {bus_rd_valid_o, bus_rd_last_o}, 2'b10);
    check(bus_rd_data_o == exp_d[31:0], n_eff == 2 ? "R7 lo data" : "R6 R8 R9 lo data", bus_rd_data_o, exp_d[31:0]);
    check(err_corr_o == (n_eff == 1) && err_uncorr_o == (n_eff == 2), "R6 R7 R8 R12 flags lo",
          {err_corr_o, err_uncorr_o}, {n_eff == 1, n_eff == 2});
    if (half_mode_i) begin
      @(negedge clk_i);
      check(!bus_rd_valid_o && !err_corr_o && !err_uncorr_o, "R5 R12 gap", bus_rd_valid_o, 0);
    end
    @(negedge clk_i);
    check(bus_rd_valid_o && bus_rd_last_o, "R3 R4 R5 second beat", {bus_rd_valid_o, bus_rd_last_o}, 2'b11);
    check(bus_rd_data_o == exp_d[63:32], n_eff == 2 ? "R7 hi data" : "R6 R8 R9 hi data", bus_rd_data_o, exp_d[63:32]);
    check(err_corr_o == (n_eff == 1) && err_uncorr_o == (n_eff == 2), "R6 R7 R12 flags hi",
          {err_corr_o, err_uncorr_o}, {n_eff == 1, n_eff == 2});
    @(negedge clk_i);
    check(!bus_rd_valid_o, "R3 idle after pair", bus_rd_valid_o, 0);
  endtask

  task automatic do_write(input logic [31:0] lo, input logic [31:0] hi);
    logic [71:0] exp_w;
    bus_wr_valid_i = 1'b1;
    bus_wr_data_i  = lo;
    if (half_mode_i) begin
      exp_w = b_encode({{32{fill_ones_i}}, lo});
      @(negedge clk_i);
      bus_wr_valid_i = 1'b0;
      check(mem_wr_valid_o && mem_wr_word_o == exp_w, "R11 R2 half write", mem_wr_word_o, exp_w);
    end else begin
      exp_w = b_encode({hi, lo});
      @(negedge clk_i);
      check(!mem_wr_valid_o, "R10 no write after one word", mem_wr_valid_o, 0);
      bus_wr_data_i = hi;
      @(negedge clk_i);
      bus_wr_valid_i = 1'b0;
      check(mem_wr_valid_o && mem_wr_word_o == exp_w, "R10 R2 full write", mem_wr_word_o, exp_w);
    end
    @(negedge clk_i);
    check(!mem_wr_valid_o, "R10 R11 single pulse", mem_wr_valid_o, 0);
  endtask

  task automatic sweep(input logic [63:0] d);
    do_read(d, -1, -1);
    for (int i = 0; i < 72; i++) do_read(d, i, -1);
    for (int i = 0; i < 72; i++) do_read(d, i, (i + 1 + i % 5) % 72);
  endtask

  initial begin
    void'($urandom(32'h5EC0DE));
    #(CLK_PERIOD * 2 + 1);
    check(!bus_rd_valid_o && !bus_rd_last_o && !err_corr_o && !err_uncorr_o && !mem_wr_valid_o,
          "R1 reset state", {bus_rd_valid_o, bus_rd_last_o, err_corr_o, err_uncorr_o, mem_wr_valid_o}, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    half_mode_i = 1'b0;
    sweep(64'h0123_4567_89AB_CDEF);
    do_read('0, -1, -1);
    do_read('1, 70, 71);
    do_write(32'hDEAD_BEEF, 32'h0BAD_F00D);
    do_write('0, '1);

    half_mode_i = 1'b1; fill_ones_i = 1'b0;
    @(negedge clk_i);
    sweep(64'hFFFF_FFFF_A5A5_5A5A);
    do_write(32'h1234_5678, '0);

    fill_ones_i = 1'b1;
    @(negedge clk_i);
    sweep(64'h0000_0000_C3C3_3C3C);
    do_write(32'h8765_4321, '0);

    for (int r = 0; r < 300; r++) begin
      int fa, fb, ne;
      half_mode_i = r[0];
      fill_ones_i = $urandom_range(1);
      @(negedge clk_i);
      ne = $urandom_range(2);
      fa = (ne > 0) ? $urandom_range(71) : -1;
      fb = -1;
      if (ne == 2) begin
        fb = $urandom_range(71);
        if (fb == fa) fb = (fa + 1) % 72;
      end
      do_read({$urandom, $urandom}, fa, fb);
      if (r % 10 == 0) do_write($urandom, $urandom);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk_i);
      cycles++;
      if (cycles > WATCHDOG && !done) begin
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end
endmodule